// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms operand and branch-target addresses for a 16-bit processor. It takes fields the decoder has already pulled out of an instruction: a mode code, a 2-bit base-register field, a 4-bit index field and a displacement byte. It also takes the current instruction counter. It drives register-file read addresses in the same cycle, and the register file returns data combinationally in that cycle. One cycle later the unit presents the 16-bit effective address with a one-cycle valid pulse.

There are three address modes. The first adds a base register to the zero-extended displacement. The second adds a base register to an index register; when the index field is zero, it falls back to base plus displacement. The third adds the sign-extended displacement to the instruction counter to give a branch target.

Base registers are limited to R12 through R15, because the 2-bit field is offset by twelve. All sums wrap modulo 2^16 and raise no flag. A small state machine has two states, ST_IDLE and ST_PRESENT, and two transitions:
- "accept" leads to ST_PRESENT from either state.
- "no accept" leads to ST_IDLE from either state.

The valid output is high exactly in ST_PRESENT.

Top module: `ea_gen`

## Requirements
- R1: `rd_base_addr` always equals the base field plus 12, so it lies in the range 12 to 15.
- R2: `rd_index_addr` always equals the 4-bit index field.
- R3: Mode code 2'b00 (base plus displacement) gives `ea` = base register data + zero-extended `disp`.
- R4: Mode code 2'b01 (indexed) with a non-zero index field gives `ea` = base register data + index register data, and `disp` has no effect.
- R5: Mode code 2'b01 with index field 0 gives `ea` = base register data + zero-extended `disp`, and `rd_index_data` has no effect.
- R6: Mode code 2'b10 (counter-relative) gives `ea` = `icount` + sign-extended `disp`, covering the range -128 to +127.
- R7: Every sum is taken modulo 2^16, and the carry out of bit 15 is dropped.
- R8: For an accepted request (`req_valid` high with a mode other than 2'b11), `ea_valid` is high in the following cycle only, and `ea` is registered and holds its value until the next accepted request.
- R9: Requests in consecutive cycles are each accepted. Each one yields its own result in the cycle after it.
- R10: Mode code 2'b11 is reserved. Such a request is not accepted: `ea_valid` stays low and `ea` is unchanged.
- R11: A synchronous active-high `rst` clears `ea` to 0 and `ea_valid` to 0, and it overrides a request present in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 2 | Mode code: 00 base+disp, 01 indexed, 10 counter-relative, 11 reserved |
| base_fld | input | 2 | Base register field (register = field + 12) |
| index_fld | input | 4 | Index register field (0 means no indexing) |
| disp | input | 8 | Displacement byte |
| icount | input | 16 | Instruction counter |
| rd_base_addr | output | 4 | Register-file read address for the base |
| rd_index_addr | output | 4 | Register-file read address for the index |
| rd_base_data | input | 16 | Base register contents |
| rd_index_data | input | 16 | Index register contents |
| ea | output | 16 | Registered effective address |
| ea_valid | output | 1 | One-cycle strobe marking a new `ea` |

## Verification
Two things overlap in a single cycle. The unit accepts a new request and drives its read addresses while it is still presenting the valid pulse and address of the previous request. The sweeps issue requests back to back with no idle gaps to force this overlap in almost every cycle. In each cycle the bench checks two things: that the read addresses match the fields just driven, and that `ea` matches the value computed arithmetically for the request of the previous cycle. Separate short sequences end a burst with an idle cycle, a reserved mode code or a reset, to show that the pulse ends and that the held address is kept or cleared.

// File: rtl/ea_gen_pkg.sv
`timescale 1ns/1ps
package ea_gen_pkg;

    typedef enum logic [1:0] {
        EM_BASE_DISP  = 2'b00,
        EM_BASE_INDEX = 2'b01,
        EM_IC_REL     = 2'b10,
        EM_RESERVED   = 2'b11
    } ea_mode_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } ea_state_e;

endpackage

// File: rtl/ea_regsel.sv
`timescale 1ns/1ps
module ea_regsel #(
    parameter int REG_AW   = 4,
    parameter int BASE_FW  = 2,
    parameter int BASE_OFS = 12
) (
    input  logic [BASE_FW-1:0] base_fld,
    input  logic [REG_AW-1:0]  index_fld,
    output logic [REG_AW-1:0]  base_addr,
    output logic [REG_AW-1:0]  index_addr,
    output logic               index_en
);
    localparam int PAD_W = REG_AW - BASE_FW;
    localparam logic [REG_AW-1:0] OFS = REG_AW'(BASE_OFS);

    // Base register number is the short field shifted up by the fixed offset.
    assign base_addr  = {{PAD_W{1'b0}}, base_fld} + OFS;
    assign index_addr = index_fld;
    // Register 0 never serves as an index.
    assign index_en   = (index_fld != '0);
endmodule

// File: rtl/ea_opmux.sv
`timescale 1ns/1ps
module ea_opmux
    import ea_gen_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8
) (
    input  ea_mode_e            mode,
    input  logic                index_en,
    input  logic [DISP_W-1:0]   disp,
    input  logic [ADDR_W-1:0]   icount,
    input  logic [ADDR_W-1:0]   base_data,
    input  logic [ADDR_W-1:0]   index_data,
    output logic [ADDR_W-1:0]   opnd_a,
    output logic [ADDR_W-1:0]   opnd_b
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_zx;
    logic [ADDR_W-1:0] disp_sx;

    assign disp_zx = {{EXT_W{1'b0}}, disp};
    assign disp_sx = {{EXT_W{disp[DISP_W-1]}}, disp};

    always_comb begin
        unique case (mode)
            EM_BASE_DISP: begin
                opnd_a = base_data;
                opnd_b = disp_zx;
            end
            EM_BASE_INDEX: begin
                opnd_a = base_data;
                opnd_b = index_en ? index_data : disp_zx;
            end
            EM_IC_REL: begin
                opnd_a = icount;
                opnd_b = disp_sx;
            end
            EM_RESERVED: begin
                opnd_a = '0;
                opnd_b = '0;
            end
        endcase
    end
endmodule

// File: rtl/ea_adder.sv
`timescale 1ns/1ps
module ea_adder #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] a,
    input  logic [ADDR_W-1:0] b,
    output logic [ADDR_W-1:0] sum
);
    // Modulo sum: the carry out of the top bit is not kept.
    assign sum = a + b;
endmodule

// File: rtl/ea_ctrl.sv
`timescale 1ns/1ps
module ea_ctrl
    import ea_gen_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  ea_mode_e          mode,
    input  logic [ADDR_W-1:0] sum,
    output logic [ADDR_W-1:0] ea,
    output logic              ea_valid
);
    ea_state_e         state_q, state_d;
    logic              accept;
    logic [ADDR_W-1:0] ea_q;

    assign accept = req_valid && (mode != EM_RESERVED);

    // Next-state decision.
    always_comb begin
        unique case (state_q)
            ST_IDLE:    state_d = accept ? ST_PRESENT : ST_IDLE;
            ST_PRESENT: state_d = accept ? ST_PRESENT : ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Address register, loaded on every accepted request.
    always_ff @(posedge clk) begin
        if (rst)         ea_q <= '0;
        else if (accept) ea_q <= sum;
    end

    // Outputs.
    always_comb begin
        ea_valid = (state_q == ST_PRESENT);
        ea       = ea_q;
    end
endmodule

// File: rtl/ea_gen.sv
`timescale 1ns/1ps
module ea_gen
    import ea_gen_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DISP_W   = 8,
    parameter int REG_AW   = 4,
    parameter int BASE_FW  = 2,
    parameter int BASE_OFS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_mode,
    input  logic [BASE_FW-1:0] base_fld,
    input  logic [REG_AW-1:0] index_fld,
    input  logic [DISP_W-1:0] disp,
    input  logic [ADDR_W-1:0] icount,
    output logic [REG_AW-1:0] rd_base_addr,
    output logic [REG_AW-1:0] rd_index_addr,
    input  logic [ADDR_W-1:0] rd_base_data,
    input  logic [ADDR_W-1:0] rd_index_data,
    output logic [ADDR_W-1:0] ea,
    output logic              ea_valid
);
    ea_mode_e          mode;
    logic              index_en;
    logic [ADDR_W-1:0] opnd_a, opnd_b, sum;

    assign mode = ea_mode_e'(req_mode);

    ea_regsel #(
        .REG_AW(REG_AW), .BASE_FW(BASE_FW), .BASE_OFS(BASE_OFS)
    ) u_regsel (
        .base_fld  (base_fld),
        .index_fld (index_fld),
        .base_addr (rd_base_addr),
        .index_addr(rd_index_addr),
        .index_en  (index_en)
    );

    ea_opmux #(
        .ADDR_W(ADDR_W), .DISP_W(DISP_W)
    ) u_opmux (
        .mode      (mode),
        .index_en  (index_en),
        .disp      (disp),
        .icount    (icount),
        .base_data (rd_base_data),
        .index_data(rd_index_data),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b)
    );

    ea_adder #(.ADDR_W(ADDR_W)) u_adder (
        .a  (opnd_a),
        .b  (opnd_b),
        .sum(sum)
    );

    ea_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .mode     (mode),
        .sum      (sum),
        .ea       (ea),
        .ea_valid (ea_valid)
    );
endmodule

// File: rtl/ea_gen_checker.sv
`timescale 1ns/1ps
module ea_gen_checker #(
    parameter int ADDR_W  = 16,
    parameter int DISP_W  = 8,
    parameter int REG_AW  = 4,
    parameter int BASE_FW = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_mode,
    input logic [REG_AW-1:0] index_fld,
    input logic [DISP_W-1:0] disp,
    input logic [ADDR_W-1:0] icount,
    input logic [REG_AW-1:0] rd_base_addr,
    input logic [ADDR_W-1:0] rd_base_data,
    input logic [ADDR_W-1:0] rd_index_data,
    input logic [ADDR_W-1:0] ea,
    input logic              ea_valid
);
    localparam logic [REG_AW-1:0] LOW_BASE = REG_AW'(12);

    assert_base_range_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> rd_base_addr >= LOW_BASE);

    assert_disp_sum_R3: assert property (@(posedge clk) disable iff (rst)
        (ea_valid && $past(req_mode) == 2'b00) |->
        ea == $past(rd_base_data) + ADDR_W'($past(disp)));

    assert_index_sum_R4: assert property (@(posedge clk) disable iff (rst)
        (ea_valid && $past(req_mode) == 2'b01 && $past(index_fld) != '0) |->
        ea == $past(rd_base_data) + $past(rd_index_data));

    assert_index_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (ea_valid && $past(req_mode) == 2'b01 && $past(index_fld) == '0) |->
        ea == $past(rd_base_data) + ADDR_W'($past(disp)));

    assert_branch_target_R6: assert property (@(posedge clk) disable iff (rst)
        (ea_valid && $past(req_mode) == 2'b10) |->
        ea == $past(icount) + ADDR_W'($signed($past(disp))));

    assert_pulse_follows_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode != 2'b11) |=> ea_valid);

    assert_no_accept_R10: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_mode != 2'b11) |=> (!ea_valid && $stable(ea)));

    assert_reset_clear_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ea_valid && ea == '0));
endmodule

bind ea_gen ea_gen_checker #(
    .ADDR_W(ADDR_W), .DISP_W(DISP_W), .REG_AW(REG_AW), .BASE_FW(BASE_FW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_mode     (req_mode),
    .index_fld    (index_fld),
    .disp         (disp),
    .icount       (icount),
    .rd_base_addr (rd_base_addr),
    .rd_base_data (rd_base_data),
    .rd_index_data(rd_index_data),
    .ea           (ea),
    .ea_valid     (ea_valid)
);

// File: tb/sim_ea_gen.sv
`timescale 1ns/1ps
module sim_ea_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_mode = 2'b00;
    logic [1:0]  base_fld = 2'b00;
    logic [3:0]  index_fld = 4'h0;
    logic [7:0]  disp = 8'h00;
    logic [15:0] icount = 16'h0000;
    logic [3:0]  rd_base_addr, rd_index_addr;
    logic [15:0] rd_base_data, rd_index_data;
    logic [15:0] ea;
    logic        ea_valid;

    logic [15:0] rf [16];
    int n_checks = 0;
    int n_errors = 0;
    logic [15:0] last_ea;

    always #2.5 clk = ~clk;

    assign rd_base_data  = rf[rd_base_addr];
    assign rd_index_data = rf[rd_index_addr];

    ea_gen u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .base_fld(base_fld), .index_fld(index_fld), .disp(disp), .icount(icount),
        .rd_base_addr(rd_base_addr), .rd_index_addr(rd_index_addr),
        .rd_base_data(rd_base_data), .rd_index_data(rd_index_data),
        .ea(ea), .ea_valid(ea_valid)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // Expected sum from the requirements, 17 bits so a wrap can be seen.
    function automatic logic [16:0] model(input logic [1:0] m, input logic [1:0] b,
                                          input logic [3:0] i, input logic [7:0] d,
                                          input logic [15:0] ic);
        logic [16:0] base;
        base = {1'b0, rf[4'(b) + 4'd12]};
        case (m)
            2'b00:   return base + {9'h0, d};
            2'b01:   return (i != 4'h0) ? base + {1'b0, rf[i]} : base + {9'h0, d};
            default: return {1'b0, ic} + {{9{d[7]}}, d};
        endcase
    endfunction

    // Drive one request at a falling edge, check the read addresses at once,
    // then check the result at the next falling edge.
    task automatic issue(input logic [1:0] m, input logic [1:0] b, input logic [3:0] i,
                         input logic [7:0] d, input logic [15:0] ic);
        logic [16:0] exp;
        string tag;
        req_valid = 1'b1; req_mode = m; base_fld = b; index_fld = i; disp = d; icount = ic;
        #1;
        check("R1", {12'h0, rd_base_addr}, {12'h0, 4'(b) + 4'd12});
        check("R2", {12'h0, rd_index_addr}, {12'h0, i});
        exp = model(m, b, i, d, ic);
        if (m == 2'b00)      tag = "R3";
        else if (m == 2'b01) tag = (i != 4'h0) ? "R4" : "R5";
        else                 tag = "R6";
        if (m != 2'b10 && exp[16]) tag = {tag, "/R7"};
        @(negedge clk);
        check("R8", {15'h0, ea_valid}, 16'h0001);
        check(tag, ea, exp[15:0]);
        last_ea = exp[15:0];
    endtask

    task automatic idle();
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int r = 0; r < 16; r++) rf[r] = 16'(r * 16'h1357) ^ 16'hA5C3;
        rf[0]  = 16'hDEAD;
        rf[15] = 16'hFFF0;
        rf[7]  = 16'h0020;

        repeat (4) @(negedge clk);
        check("R11", ea, 16'h0000);
        check("R11", {15'h0, ea_valid}, 16'h0000);
        rst = 1'b0;

        // Back-to-back sweeps over every field combination (R9 overlap).
        for (int m = 0; m < 3; m++)
            for (int b = 0; b < 4; b++)
                for (int i = 0; i < 16; i++)
                    for (int d = 0; d < 256; d++)
                        issue(2'(m), 2'(b), 4'(i), 8'(d),
                              16'(i * 16'h1111) + 16'(b * 16'h0400) + 16'h0F80);

        // R7: explicit wraps at both ends of the counter range.
        issue(2'b10, 2'b00, 4'h0, 8'h01, 16'hFFFF);
        check("R7", ea, 16'h0000);
        issue(2'b10, 2'b00, 4'h0, 8'h80, 16'h0000);
        check("R6", ea, 16'hFF80);
        issue(2'b01, 2'b11, 4'h7, 8'hAA, 16'h0000);
        check("R7", ea, 16'h0010);

        // R8: pulse ends after one cycle and the address holds.
        idle();
        check("R8", {15'h0, ea_valid}, 16'h0000);
        check("R8", ea, last_ea);

        // R9: two distinct requests back to back, then idle.
        issue(2'b00, 2'b01, 4'h3, 8'h10, 16'h0);
        issue(2'b10, 2'b00, 4'h0, 8'h05, 16'h1000);
        check("R9", ea, 16'h1005);
        idle();
        check("R9", {15'h0, ea_valid}, 16'h0000);

        // R10: reserved mode after a valid result.
        issue(2'b00, 2'b10, 4'h0, 8'h33, 16'h0);
        req_valid = 1'b1; req_mode = 2'b11; disp = 8'h77; icount = 16'h4444;
        @(negedge clk);
        check("R10", {15'h0, ea_valid}, 16'h0000);
        check("R10", ea, last_ea);
        idle();
        check("R10", ea, last_ea);

        // R11: reset overrides a request present in the same cycle.
        issue(2'b10, 2'b00, 4'h0, 8'h12, 16'h2222);
        rst = 1'b1; req_valid = 1'b1; req_mode = 2'b00;
        @(negedge clk);
        check("R11", ea, 16'h0000);
        check("R11", {15'h0, ea_valid}, 16'h0000);
        rst = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        check("R11", {15'h0, ea_valid}, 16'h0000);

        finish_run();
    end
endmodule